// File: doc/BRIEF.md
# Word Rotate-and-Mask Unit

This execution unit serves a 64-bit integer datapath and carries out the three word-rotate operations: rotate by an immediate count and AND with a mask, rotate by a count taken from a register and AND with a mask, and rotate by an immediate count and merge into a target value under a mask. The low 32 bits of the source are duplicated side by side to form a 64-bit doubled word, and that doubled word is rotated left. The upper half of the result therefore carries data, not zeros.

The mask is defined over 64 positions numbered 0 (MSB) to 63 (LSB) and runs from position mask_begin+32 to position mask_end+32. When mask_begin exceeds mask_end, the mask wraps around and also covers the whole upper word. The result is registered, and a valid flag is raised one cycle after each input strobe. There is no back-pressure.

Top module: `rotmask_unit`

## Requirements
- R1: While rst_n is low, out_valid is 0 and result is 0.
- R2: out_valid is 1 in exactly the cycle after a cycle in which in_valid is 1, for every opcode.
- R3: When in_valid is 0, result keeps its previous value.
- R4: The rotated value is two copies of src[31:0] placed side by side, then rotated left by the count. For op 0 the count is sh_imm. For op 0 and op 1 the result is the rotated value ANDed with the mask.
- R5: When mask_begin <= mask_end, the mask covers only bits (31-mask_end) down to (31-mask_begin), counted from the LSB. Result bits 63:32 are then 0 for the AND forms.
- R6: When mask_begin > mask_end, the mask covers every bit except bits (32-mask_begin) through (30-mask_end), counted from the LSB. This includes all of bits 63:32.
- R7: For op 1 the rotate count is amt_reg[4:0]. amt_reg[63:5] and sh_imm have no effect, so an amt_reg of 7FFFFFFFFFFFFFFF rotates by 31.
- R8: For op 2 (insert), each result bit is the rotated bit where the mask is 1 and the tgt bit where the mask is 0.
- R9: Insert with mask_begin=31 and mask_end=0 takes all of bits 63:32 plus bits 31 and 0 from the rotated value, and bits 30:1 from tgt.
- R10: Opcode encoding: 0 is immediate-AND, 1 is register-AND, 2 is insert, and 3 behaves exactly as 0. For ops 0, 2 and 3, amt_reg has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 2 | Operation select |
| src | input | 64 | Source operand; only the low word is rotated |
| tgt | input | 64 | Target value merged by the insert form |
| amt_reg | input | 64 | Register rotate-count operand |
| sh_imm | input | 5 | Immediate rotate count |
| mask_begin | input | 5 | Mask begin field |
| mask_end | input | 5 | Mask end field |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| result | output | 64 | Registered result |

## Verification
The bench aims at the cases where a design that zero-pads the upper half shows up as zeros in result[63:32] after a wrapping mask. It covers the mask_begin=31/mask_end=0 insert, where a design that special-cases the whole word differs from the plain wrap rule in bits 31 and 0. It drives register counts whose upper bits are set, so a design that uses more than five count bits rotates by the wrong amount. It drives an opcode-3 encoding and contiguous masks, which must leave the upper word clear. Randomized operands and mask fields are then compared against a bit-by-bit model of the doubled-word rotation and the wrap-around mask.

// File: rtl/rotmask_unit.sv
module rotmask_unit #(
  parameter int XLEN = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [1:0]                    op,
  input  logic [XLEN-1:0]               src,
  input  logic [XLEN-1:0]               tgt,
  input  logic [XLEN-1:0]               amt_reg,
  input  logic [$clog2(XLEN/2)-1:0]     sh_imm,
  input  logic [$clog2(XLEN/2)-1:0]     mask_begin,
  input  logic [$clog2(XLEN/2)-1:0]     mask_end,
  output logic                          out_valid,
  output logic [XLEN-1:0]               result
);
  localparam int WLEN = XLEN / 2;
  localparam int SW   = $clog2(WLEN);
  localparam logic [1:0] OP_REG_AND = 2'd1;
  localparam logic [1:0] OP_INSERT  = 2'd2;

  logic [SW-1:0]   count;
  logic [XLEN-1:0] doubled, shifted, rot, mask, next_res;
  logic [WLEN-1:0] rot_w, mask_lo;
  logic            wrap;
  logic            unused_bits;

  assign count   = (op == OP_REG_AND) ? amt_reg[SW-1:0] : sh_imm;
  assign doubled = {src[WLEN-1:0], src[WLEN-1:0]};
  assign shifted = doubled << count;
  assign rot_w   = shifted[XLEN-1:WLEN];
  assign rot     = {rot_w, rot_w};
  assign wrap    = mask_begin > mask_end;

  generate
    for (genvar i = 0; i < WLEN; i++) begin : g_mask
      localparam logic [SW-1:0] POS = SW'(WLEN - 1 - i);
      assign mask_lo[i] = wrap ? (POS >= mask_begin || POS <= mask_end)
                               : (POS >= mask_begin && POS <= mask_end);
    end
  endgenerate

  assign mask     = {{WLEN{wrap}}, mask_lo};
  assign next_res = (op == OP_INSERT) ? ((rot & mask) | (tgt & ~mask)) : (rot & mask);

  assign unused_bits = ^{src[XLEN-1:WLEN], amt_reg[XLEN-1:SW]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_res;
    end
  end
endmodule

module rotmask_unit_chk #(
  parameter int XLEN = 64
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      in_valid,
  input logic [1:0]                op,
  input logic [XLEN-1:0]           tgt,
  input logic [$clog2(XLEN/2)-1:0] mask_begin,
  input logic [$clog2(XLEN/2)-1:0] mask_end,
  input logic                      out_valid,
  input logic [XLEN-1:0]           result
);
  localparam int WLEN = XLEN / 2;

  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R3
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
  // R5
  upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op != 2'd2 && mask_begin <= mask_end) |=> result[XLEN-1:WLEN] == '0);
  // R6
  wrap_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op != 2'd2 && mask_begin > mask_end)
      |=> (result[WLEN-1:0] & ~result[XLEN-1:WLEN]) == '0);
  // R8
  insert_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'd2 && mask_begin <= mask_end)
      |=> result[XLEN-1:WLEN] == $past(tgt[XLEN-1:WLEN]));
endmodule

bind rotmask_unit rotmask_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .tgt(tgt),
  .mask_begin(mask_begin), .mask_end(mask_end),
  .out_valid(out_valid), .result(result)
);

// File: tb/rotmask_unit_tb.sv
`timescale 1ns/1ps
module rotmask_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  op = '0;
  logic [63:0] src = '0, tgt = '0, amt_reg = '0;
  logic [4:0]  sh_imm = '0, mask_begin = '0, mask_end = '0;
  logic        out_valid;
  logic [63:0] result;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rotmask_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .src(src), .tgt(tgt),
    .amt_reg(amt_reg), .sh_imm(sh_imm), .mask_begin(mask_begin), .mask_end(mask_end),
    .out_valid(out_valid), .result(result)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [63:0] src;
    logic [63:0] tgt;
    logic [63:0] amt;
    logic [4:0]  sh;
    logic [4:0]  mb;
    logic [4:0]  me;
    logic [63:0] exp;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 64'hF7487D82EC6F75DF, 64'h0, 64'h0, 5'd5, 5'd12, 5'd4, 64'h8DEEBBFD880EBBFD},
    '{2'd2, 64'hFFFFFFFFFFFFFFF0, 64'hFFFFFFFFFFFFFFF0, 64'h0, 5'd29, 5'd14, 5'd1, 64'h1FFFFFFE3FFFFFFE},
    '{2'd2, 64'hED7EB4DD824F0853, 64'hED7EB4DD824F0853, 64'h0, 5'd10, 5'd31, 5'd0, 64'h3C214E09024F0853},
    '{2'd1, 64'h0000000000000002, 64'h0, 64'h7FFFFFFFFFFFFFFF, 5'd0, 5'd31, 5'd16, 64'h0000000100000001},
    '{2'd0, 64'h0000000080000001, 64'h0, 64'h000000000000001F, 5'd1, 5'd0, 5'd31, 64'h0000000000000003},
    '{2'd3, 64'h0000000080000001, 64'h0, 64'h000000000000001F, 5'd1, 5'd0, 5'd31, 64'h0000000000000003},
    '{2'd1, 64'h0000000012345678, 64'h0, 64'hFFFFFFFFFFFFFFE0, 5'd7, 5'd0, 5'd31, 64'h0000000012345678},
    '{2'd2, 64'hAAAAAAAA000000FF, 64'h1111111122222222, 64'h0, 5'd8, 5'd16, 5'd23, 64'h111111112222FF22}
  };

  function automatic string vec_tag(int i);
    case (i)
      0: return "R6";
      1: return "R8";
      2: return "R9";
      3: return "R7";
      4: return "R5";
      5: return "R10";
      6: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [63:0] model(logic [1:0] o, logic [63:0] s, logic [63:0] t,
                                        logic [63:0] a, logic [4:0] sh, logic [4:0] mb,
                                        logic [4:0] me);
    int n;
    logic [31:0] r;
    logic [63:0] rr, m;
    n = (o == 2'd1) ? int'(a[4:0]) : int'(sh);
    for (int k = 0; k < 32; k++) r[(k + n) % 32] = s[k];
    rr = {r, r};
    for (int p = 0; p < 64; p++) begin
      if (mb <= me) m[63-p] = (p >= int'(mb) + 32) && (p <= int'(me) + 32);
      else          m[63-p] = !((p > int'(me) + 32) && (p < int'(mb) + 32));
    end
    return (o == 2'd2) ? ((rr & m) | (t & ~m)) : (rr & m);
  endfunction

  task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(string tag, logic [1:0] o, logic [63:0] s, logic [63:0] t,
                       logic [63:0] a, logic [4:0] sh, logic [4:0] mb, logic [4:0] me,
                       logic [63:0] exp);
    @(negedge clk);
    op = o; src = s; tgt = t; amt_reg = a; sh_imm = sh; mask_begin = mb; mask_end = me;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check64(tag, result, exp);
    check64("R2", {63'b0, out_valid}, 64'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    in_valid = 1'b1;
    src = 64'hFFFFFFFFFFFFFFFF;
    mask_begin = 5'd31;
    repeat (3) @(negedge clk);
    check64("R1", {63'b0, out_valid}, 64'd0);
    check64("R1", result, 64'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++)
      apply(vec_tag(i), VECS[i].op, VECS[i].src, VECS[i].tgt, VECS[i].amt,
            VECS[i].sh, VECS[i].mb, VECS[i].me, VECS[i].exp);

    // R3: inputs change with in_valid low; result holds, valid drops
    @(negedge clk);
    op = 2'd0; src = 64'h123456789ABCDEF0; sh_imm = 5'd3; mask_begin = 5'd5; mask_end = 5'd2;
    @(negedge clk);
    check64("R3", result, 64'h111111112222FF22);
    check64("R2", {63'b0, out_valid}, 64'd0);

    // R9: insert with begin 31, end 0 against a zero target
    apply("R9", 2'd2, 64'h00000000FFFFFFFF, 64'h0, 64'h0, 5'd0, 5'd31, 5'd0,
          64'hFFFFFFFF80000001);
    // R4: immediate AND, full contiguous low-word mask, rotate by 31
    apply("R4", 2'd0, 64'hDEADBEEF00000003, 64'h0, 64'h0, 5'd31, 5'd0, 5'd31,
          64'h0000000080000001);
    // R10: insert ignores amt_reg
    apply("R10", 2'd2, 64'h0000000000000001, 64'hFFFFFFFFFFFFFFFF, 64'h1F, 5'd4, 5'd27, 5'd27,
          64'hFFFFFFFFFFFFFFFF);

    for (int j = 0; j < 400; j++) begin
      logic [1:0]  o;
      logic [63:0] s, t, a;
      logic [4:0]  sh, mb, me;
      string tag;
      o  = 2'($urandom);
      s  = {$urandom, $urandom};
      t  = {$urandom, $urandom};
      a  = {$urandom, $urandom};
      sh = 5'($urandom);
      mb = 5'($urandom);
      me = 5'($urandom);
      tag = (o == 2'd2) ? "R8" : (o == 2'd1) ? "R7" : (mb > me) ? "R6" : "R4";
      apply(tag, o, s, t, a, sh, mb, me, model(o, s, t, a, sh, mb, me));
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule